// File: doc/BRIEF.md
# VME Slave Window Decoder and Bridge Register File

This block is the bus-slave front end of a carrier board that hosts two PCI add-in slots behind a VME interface. Each incoming access carries an address, an address-space flag, a direction, a data size and write data. The block compares the access against a single 64 KB board window. Two 4-bit switch inputs place the window, and a strap puts it in either the 32-bit (extended) or the 24-bit (standard) address space. Accesses that miss the window are ignored entirely.

Inside the window, only the lowest 2 KB are mapped. The first kilobyte holds the bridge's own 16-bit registers. The rest is split into 256-byte regions: configuration space and I/O space, one of each per slot. For every hit the block registers a select strobe that carries a region code, a slot number and the low 16 address bits unchanged. The downstream PCI cycle generator uses this strobe to start configuration or I/O cycles. Register accesses and accesses to the unmapped upper part of the window are answered locally, one cycle after the access.

The register file holds:
- an identification word and a revision word;
- a control word that drives four LEDs, per-slot power and per-slot memory enables;
- an interrupt vector and level;
- a status word with the per-slot interrupt-pending inputs;
- three 16-bit memory-window words per slot (base, mask, translation).

Top module: `carrier_slave_front`

## Requirements
- R1: In extended mode (strap_ext=1) an access hits only when acc_ext=1, acc_addr[31:24] equals {sw_hi,sw_lo} and acc_addr[23:16] is zero. A miss produces no sel_valid and no rsp_valid.
- R2: In standard mode (strap_ext=0) an access hits only when acc_ext=0 and acc_addr[23:16] equals {sw_hi,sw_lo}. acc_addr[31:24] is ignored.
- R3: A hit raises sel_valid one cycle later, with sel_addr = acc_addr[15:0]. The region code on sel_region is set from the offset: 0x000–0x3FF gives 0 (register), 0x400–0x5FF gives 1 (configuration), 0x600–0x7FF gives 2 (I/O), and 0x800 and above gives 3 (unmapped). sel_slot equals offset bit 8, so 0 is slot A and 1 is slot B.
- R4: Register and unmapped hits raise rsp_valid in the same cycle as sel_valid. Configuration and I/O hits never raise rsp_valid.
- R5: Word 0x0 reads 0x2014 and word 0x2 reads the revision parameter. Writes to either have no effect.
- R6: The control word at 0x4 resets to 0. Bits 3:0 are the LEDs (1 = on), bit 8 powers slot A, bit 9 powers slot B, bit 10 enables slot A memory and bit 11 enables slot B memory. All other bits read 0.
- R7: The word at 0x6 holds the interrupt vector in bits 7:0 and the level in bits 10:8. It resets to 0, and its other bits read 0.
- R8: The status word at 0x8 is read-only. Bit 0 shows irq_pend[0] (slot A) and bit 1 shows irq_pend[1] (slot B), as sampled at the access. Its other bits read 0.
- R9: Base, mask and translation words sit at 0xA, 0xC and 0xE for slot A and at 0x10, 0x12 and 0x14 for slot B. They reset to 0, are fully read/write, and appear on win_base, win_mask and win_xlat, with slot A in bits 15:0.
- R10: A register access with acc_size 2 (D32) or 3 raises rsp_berr, returns 0 and changes no register. D8 (0) and D16 (1) complete normally.
- R11: An unmapped hit is answered with read data 0 and no rsp_berr, and a write there changes no register. Register offsets that hold no register also read 0 and ignore writes.
- R12: An access whose acc_ext differs from the strap misses, even if its address bits would match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_hi | input | SW_W | Upper switch nibble of the window position |
| sw_lo | input | SW_W | Lower switch nibble of the window position |
| strap_ext | input | 1 | 1 = extended 32-bit space, 0 = standard 24-bit space |
| acc_valid | input | 1 | One-cycle access strobe |
| acc_addr | input | 32 | Access address |
| acc_ext | input | 1 | Access address-space flag (1 = extended) |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_size | input | 2 | 0 = D8, 1 = D16, 2 = D32, 3 = reserved |
| acc_wdata | input | 16 | Write data |
| irq_pend | input | 2 | Interrupt pending from slot B (bit 1) and slot A (bit 0) |
| sel_valid | output | 1 | Registered hit strobe |
| sel_region | output | 2 | Region code of the last hit |
| sel_slot | output | 1 | Slot of the last hit |
| sel_addr | output | 16 | Low address bits of the last hit |
| rsp_valid | output | 1 | Local completion strobe |
| rsp_berr | output | 1 | Bus error on local completion |
| rsp_rdata | output | 16 | Local read data |
| led | output | LED_N | LED drives |
| slot_pwr | output | 2 | Slot power switches |
| mem_en | output | 2 | Slot memory window enables |
| irq_vec | output | VEC_W | Interrupt vector |
| irq_lvl | output | LVL_W | Interrupt level |
| win_base | output | 32 | Base words, slot B in 31:16 |
| win_mask | output | 32 | Mask words, slot B in 31:16 |
| win_xlat | output | 32 | Translation words, slot B in 31:16 |

## Verification
Random accesses spread over misses, every sub-region and the register words. Directed sweeps across the four region boundaries show whether the offset decode splits at the right bit. Flipping the strap, and sending accesses whose space flag disagrees with it, separates the extended-mode compare from the standard-mode compare, including the ignored upper byte in standard mode. Wide register writes and writes to read-only, empty or unmapped offsets are each followed by read-backs, which show that nothing changed. Writes of all-ones expose any stored bit outside the defined fields.

// File: rtl/csf_pkg.sv
package csf_pkg;
   localparam int NUM_SLOTS = 2;
   localparam int WORD_W    = 16;
   localparam int IDX_W     = 9;

   typedef enum logic [1:0] {
      RGN_REG  = 2'd0,
      RGN_CFG  = 2'd1,
      RGN_IO   = 2'd2,
      RGN_NONE = 2'd3
   } rgn_e;

   // word indices (byte offset / 2)
   localparam logic [IDX_W-1:0] IDX_DEV  = 9'd0;
   localparam logic [IDX_W-1:0] IDX_REV  = 9'd1;
   localparam logic [IDX_W-1:0] IDX_CTL  = 9'd2;
   localparam logic [IDX_W-1:0] IDX_VEC  = 9'd3;
   localparam logic [IDX_W-1:0] IDX_STS  = 9'd4;
   localparam int               IDX_WIN0 = 5;
   localparam int               WIN_KINDS = 3;   // base, mask, translation

   // control word field positions
   localparam int CTL_PWR_LSB = 8;
   localparam int CTL_MEN_LSB = 10;
   localparam int VEC_LVL_LSB = 8;
endpackage

// File: rtl/csf_win_match.sv
module csf_win_match #(
   parameter int SW_W = 4
) (
   input  logic [31:0]     addr,
   input  logic            acc_ext,
   input  logic            strap_ext,
   input  logic [SW_W-1:0] sw_hi,
   input  logic [SW_W-1:0] sw_lo,
   output logic            hit
);
   localparam int SEL_W = 2 * SW_W;

   if (SEL_W != 8) begin : g_bad_sw
      $error("csf_win_match: switch pair must form one byte");
   end

   logic [SEL_W-1:0] pos;
   logic             ext_hit;
   logic             std_hit;

   assign pos     = {sw_hi, sw_lo};
   assign ext_hit = (addr[31:24] == pos) && (addr[23:16] == 8'h00);
   assign std_hit = (addr[23:16] == pos);

   always_comb begin
      if (acc_ext != strap_ext) hit = 1'b0;
      else if (strap_ext)       hit = ext_hit;
      else                      hit = std_hit;
   end
endmodule

// File: rtl/csf_region_dec.sv
module csf_region_dec
   import csf_pkg::*;
(
   input  logic [15:0] offset,
   output rgn_e        region,
   output logic        slot
);
   always_comb begin
      slot = offset[8];
      if (offset[15:11] != 5'd0) begin
         region = RGN_NONE;
      end else begin
         unique case (offset[10:9])
            2'b00, 2'b01: region = RGN_REG;
            2'b10:        region = RGN_CFG;
            default:      region = RGN_IO;
         endcase
      end
   end
endmodule

// File: rtl/csf_reg_file.sv
module csf_reg_file
   import csf_pkg::*;
#(
   parameter logic [15:0] DEV_ID = 16'h2014,
   parameter logic [15:0] REV_ID = 16'h0001,
   parameter int          LED_N  = 4,
   parameter int          VEC_W  = 8,
   parameter int          LVL_W  = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [IDX_W-1:0]            idx,
   input  logic [WORD_W-1:0]           wdata,
   input  logic [NUM_SLOTS-1:0]        irq_pend,
   output logic [WORD_W-1:0]           rdata,
   output logic [LED_N-1:0]            led,
   output logic [NUM_SLOTS-1:0]        slot_pwr,
   output logic [NUM_SLOTS-1:0]        mem_en,
   output logic [VEC_W-1:0]            irq_vec,
   output logic [LVL_W-1:0]            irq_lvl,
   output logic [NUM_SLOTS*WORD_W-1:0] win_base,
   output logic [NUM_SLOTS*WORD_W-1:0] win_mask,
   output logic [NUM_SLOTS*WORD_W-1:0] win_xlat
);
   if (LED_N < 1 || LED_N > CTL_PWR_LSB) begin : g_bad_led
      $error("csf_reg_file: LED count does not fit below the power bits");
   end
   if (VEC_W < 1 || VEC_W > VEC_LVL_LSB) begin : g_bad_vec
      $error("csf_reg_file: vector width does not fit below the level field");
   end
   if (LVL_W < 1 || LVL_W + VEC_LVL_LSB > WORD_W) begin : g_bad_lvl
      $error("csf_reg_file: level width does not fit the word");
   end

   logic [LED_N-1:0]     led_q;
   logic [NUM_SLOTS-1:0] pwr_q;
   logic [NUM_SLOTS-1:0] men_q;
   logic [VEC_W-1:0]     vec_q;
   logic [LVL_W-1:0]     lvl_q;
   logic [WORD_W-1:0]    win_q [NUM_SLOTS][WIN_KINDS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         led_q <= '0;
         pwr_q <= '0;
         men_q <= '0;
      end else if (wr_en && idx == IDX_CTL) begin
         led_q <= wdata[LED_N-1:0];
         pwr_q <= wdata[CTL_PWR_LSB +: NUM_SLOTS];
         men_q <= wdata[CTL_MEN_LSB +: NUM_SLOTS];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_q <= '0;
         lvl_q <= '0;
      end else if (wr_en && idx == IDX_VEC) begin
         vec_q <= wdata[VEC_W-1:0];
         lvl_q <= wdata[VEC_LVL_LSB +: LVL_W];
      end
   end

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      for (genvar k = 0; k < WIN_KINDS; k++) begin : g_kind
         localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(IDX_WIN0 + s * WIN_KINDS + k);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      win_q[s][k] <= '0;
            else if (wr_en && idx == MY_IDX) win_q[s][k] <= wdata;
         end
      end
      assign win_base[s*WORD_W +: WORD_W] = win_q[s][0];
      assign win_mask[s*WORD_W +: WORD_W] = win_q[s][1];
      assign win_xlat[s*WORD_W +: WORD_W] = win_q[s][2];
   end

   always_comb begin
      rdata = '0;
      if (idx == IDX_DEV) begin
         rdata = DEV_ID;
      end else if (idx == IDX_REV) begin
         rdata = REV_ID;
      end else if (idx == IDX_CTL) begin
         rdata[LED_N-1:0]                = led_q;
         rdata[CTL_PWR_LSB +: NUM_SLOTS] = pwr_q;
         rdata[CTL_MEN_LSB +: NUM_SLOTS] = men_q;
      end else if (idx == IDX_VEC) begin
         rdata[VEC_W-1:0]                = vec_q;
         rdata[VEC_LVL_LSB +: LVL_W]     = lvl_q;
      end else if (idx == IDX_STS) begin
         rdata[NUM_SLOTS-1:0]            = irq_pend;
      end else begin
         for (int s = 0; s < NUM_SLOTS; s++) begin
            for (int k = 0; k < WIN_KINDS; k++) begin
               if (idx == IDX_W'(IDX_WIN0 + s * WIN_KINDS + k)) rdata = win_q[s][k];
            end
         end
      end
   end

   assign led      = led_q;
   assign slot_pwr = pwr_q;
   assign mem_en   = men_q;
   assign irq_vec  = vec_q;
   assign irq_lvl  = lvl_q;
endmodule

// File: rtl/carrier_slave_front.sv
module carrier_slave_front
   import csf_pkg::*;
#(
   parameter int          SW_W   = 4,
   parameter int          LED_N  = 4,
   parameter int          VEC_W  = 8,
   parameter int          LVL_W  = 3,
   parameter logic [15:0] DEV_ID = 16'h2014,
   parameter logic [15:0] REV_ID = 16'h0001
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SW_W-1:0]  sw_hi,
   input  logic [SW_W-1:0]  sw_lo,
   input  logic             strap_ext,
   input  logic             acc_valid,
   input  logic [31:0]      acc_addr,
   input  logic             acc_ext,
   input  logic             acc_write,
   input  logic [1:0]       acc_size,
   input  logic [15:0]      acc_wdata,
   input  logic [1:0]       irq_pend,
   output logic             sel_valid,
   output logic [1:0]       sel_region,
   output logic             sel_slot,
   output logic [15:0]      sel_addr,
   output logic             rsp_valid,
   output logic             rsp_berr,
   output logic [15:0]      rsp_rdata,
   output logic [LED_N-1:0] led,
   output logic [1:0]       slot_pwr,
   output logic [1:0]       mem_en,
   output logic [VEC_W-1:0] irq_vec,
   output logic [LVL_W-1:0] irq_lvl,
   output logic [31:0]      win_base,
   output logic [31:0]      win_mask,
   output logic [31:0]      win_xlat
);
   logic        hit;
   rgn_e        rgn;
   logic        slot;
   logic        take;
   logic        wide;
   logic        is_reg;
   logic        local_done;
   logic        reg_wr;
   logic [15:0] reg_rd;

   csf_win_match #(.SW_W(SW_W)) u_match (
      .addr      (acc_addr),
      .acc_ext   (acc_ext),
      .strap_ext (strap_ext),
      .sw_hi     (sw_hi),
      .sw_lo     (sw_lo),
      .hit       (hit)
   );

   csf_region_dec u_dec (
      .offset (acc_addr[15:0]),
      .region (rgn),
      .slot   (slot)
   );

   assign take       = acc_valid && hit;
   assign wide       = acc_size[1];
   assign is_reg     = (rgn == RGN_REG);
   assign local_done = is_reg || (rgn == RGN_NONE);
   assign reg_wr     = take && is_reg && acc_write && !wide;

   csf_reg_file #(
      .DEV_ID (DEV_ID),
      .REV_ID (REV_ID),
      .LED_N  (LED_N),
      .VEC_W  (VEC_W),
      .LVL_W  (LVL_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_wr),
      .idx      (acc_addr[IDX_W:1]),
      .wdata    (acc_wdata),
      .irq_pend (irq_pend),
      .rdata    (reg_rd),
      .led      (led),
      .slot_pwr (slot_pwr),
      .mem_en   (mem_en),
      .irq_vec  (irq_vec),
      .irq_lvl  (irq_lvl),
      .win_base (win_base),
      .win_mask (win_mask),
      .win_xlat (win_xlat)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_valid  <= 1'b0;
         sel_region <= RGN_NONE;
         sel_slot   <= 1'b0;
         sel_addr   <= '0;
         rsp_valid  <= 1'b0;
         rsp_berr   <= 1'b0;
         rsp_rdata  <= '0;
      end else begin
         sel_valid <= take;
         rsp_valid <= take && local_done;
         rsp_berr  <= take && is_reg && wide;
         rsp_rdata <= (take && is_reg && !wide && !acc_write) ? reg_rd : '0;
         if (take) begin
            sel_region <= rgn;
            sel_slot   <= slot;
            sel_addr   <= acc_addr[15:0];
         end
      end
   end
endmodule

// File: rtl/carrier_slave_front_chk.sv
module carrier_slave_front_chk #(
   parameter int LED_N = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             acc_valid,
   input logic             sel_valid,
   input logic [1:0]       sel_region,
   input logic             rsp_valid,
   input logic             rsp_berr,
   input logic [15:0]      rsp_rdata,
   input logic [LED_N-1:0] led,
   input logic [1:0]       slot_pwr,
   input logic [1:0]       mem_en
);
   // R3: a select strobe only follows an access
   p_sel_follows_acc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sel_valid |-> $past(acc_valid));

   // R4: local completion only with a select strobe
   p_rsp_with_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> sel_valid);

   // R4: configuration and I/O hits are not completed locally
   p_pci_no_rsp_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_valid && (sel_region == 2'd1 || sel_region == 2'd2)) |-> !rsp_valid);

   // R10: bus error only on a register completion
   p_berr_reg_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_berr |-> (rsp_valid && sel_region == 2'd0));

   // R10: a rejected wide access leaves control outputs alone
   p_berr_keeps_ctl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_berr |-> ($stable(led) && $stable(slot_pwr) && $stable(mem_en)));

   // R11: unmapped hits answer zero without error
   p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_valid && sel_region == 2'd3) |-> (rsp_valid && !rsp_berr && rsp_rdata == 16'h0));
endmodule

bind carrier_slave_front carrier_slave_front_chk #(.LED_N(LED_N)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .acc_valid  (acc_valid),
   .sel_valid  (sel_valid),
   .sel_region (sel_region),
   .rsp_valid  (rsp_valid),
   .rsp_berr   (rsp_berr),
   .rsp_rdata  (rsp_rdata),
   .led        (led),
   .slot_pwr   (slot_pwr),
   .mem_en     (mem_en)
);

// File: tb/carrier_slave_front_tb_top.sv
module carrier_slave_front_tb_top;
   localparam logic [15:0] REV = 16'h0031;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  sw_hi = 4'hA;
   logic [3:0]  sw_lo = 4'h5;
   logic        strap_ext = 1'b1;
   logic        acc_valid = 1'b0;
   logic [31:0] acc_addr = '0;
   logic        acc_ext = 1'b0;
   logic        acc_write = 1'b0;
   logic [1:0]  acc_size = 2'd1;
   logic [15:0] acc_wdata = '0;
   logic [1:0]  irq_pend = 2'b00;
   logic        sel_valid;
   logic [1:0]  sel_region;
   logic        sel_slot;
   logic [15:0] sel_addr;
   logic        rsp_valid;
   logic        rsp_berr;
   logic [15:0] rsp_rdata;
   logic [3:0]  led;
   logic [1:0]  slot_pwr;
   logic [1:0]  mem_en;
   logic [7:0]  irq_vec;
   logic [2:0]  irq_lvl;
   logic [31:0] win_base;
   logic [31:0] win_mask;
   logic [31:0] win_xlat;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   // bench model
   logic [15:0] m_ctl = '0;
   logic [15:0] m_vec = '0;
   logic [15:0] m_win [6];

   always #5 clk = ~clk;

   carrier_slave_front #(.REV_ID(REV)) dut_i (
      .clk(clk), .rst_n(rst_n), .sw_hi(sw_hi), .sw_lo(sw_lo), .strap_ext(strap_ext),
      .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_ext(acc_ext), .acc_write(acc_write),
      .acc_size(acc_size), .acc_wdata(acc_wdata), .irq_pend(irq_pend),
      .sel_valid(sel_valid), .sel_region(sel_region), .sel_slot(sel_slot), .sel_addr(sel_addr),
      .rsp_valid(rsp_valid), .rsp_berr(rsp_berr), .rsp_rdata(rsp_rdata),
      .led(led), .slot_pwr(slot_pwr), .mem_en(mem_en), .irq_vec(irq_vec), .irq_lvl(irq_lvl),
      .win_base(win_base), .win_mask(win_mask), .win_xlat(win_xlat)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic bit exp_hit(logic [31:0] a, logic ext);
      if (ext != strap_ext) return 1'b0;
      if (strap_ext) return (a[31:24] == {sw_hi, sw_lo}) && (a[23:16] == 8'h00);
      return a[23:16] == {sw_hi, sw_lo};
   endfunction

   function automatic logic [1:0] exp_rgn(logic [15:0] off);
      if (off >= 16'h0800) return 2'd3;
      if (off < 16'h0400)  return 2'd0;
      if (off < 16'h0600)  return 2'd1;
      return 2'd2;
   endfunction

   function automatic logic [15:0] exp_read(logic [15:0] off, logic [1:0] irq);
      int w = int'(off[9:1]);
      case (w)
         0: return 16'h2014;
         1: return REV;
         2: return m_ctl;
         3: return m_vec;
         4: return {14'd0, irq};
         5, 6, 7, 8, 9, 10: return m_win[w-5];
         default: return 16'h0;
      endcase
   endfunction

   function automatic void model_write(logic [15:0] off, logic [15:0] d);
      int w = int'(off[9:1]);
      case (w)
         2: m_ctl = d & 16'h0F0F;
         3: m_vec = d & 16'h07FF;
         5, 6, 7, 8, 9, 10: m_win[w-5] = d;
         default: ;
      endcase
   endfunction

   task automatic check_outputs(string req);
      chk({req, " led"},  {28'd0, led},      {28'd0, m_ctl[3:0]});
      chk({req, " pwr"},  {30'd0, slot_pwr}, {30'd0, m_ctl[9:8]});
      chk({req, " men"},  {30'd0, mem_en},   {30'd0, m_ctl[11:10]});
      chk({req, " vec"},  {21'd0, irq_lvl, irq_vec}, {16'd0, m_vec});
      chk({req, " base"}, win_base, {m_win[3], m_win[0]});
      chk({req, " mask"}, win_mask, {m_win[4], m_win[1]});
      chk({req, " xlat"}, win_xlat, {m_win[5], m_win[2]});
   endtask

   // one access: drive at negedge, DUT registers at posedge, check at next negedge
   task automatic access(logic [31:0] a, logic ext, logic wr, logic [1:0] sz,
                         logic [15:0] d, logic [1:0] irq, string req);
      bit h;
      logic [1:0] r;
      logic [15:0] e_rd;
      bit e_berr;
      @(negedge clk);
      acc_valid = 1'b1; acc_addr = a; acc_ext = ext; acc_write = wr;
      acc_size = sz; acc_wdata = d; irq_pend = irq;
      h = exp_hit(a, ext);
      r = exp_rgn(a[15:0]);
      e_berr = h && (r == 2'd0) && sz[1];
      e_rd = (h && r == 2'd0 && !sz[1] && !wr) ? exp_read(a[15:0], irq) : 16'h0;
      @(negedge clk);
      acc_valid = 1'b0;
      chk({req, " sel_valid"}, {31'd0, sel_valid}, {31'd0, h});
      chk({req, " rsp_valid"}, {31'd0, rsp_valid}, {31'd0, h && (r == 2'd0 || r == 2'd3)});
      chk({req, " berr"}, {31'd0, rsp_berr}, {31'd0, e_berr});
      if (h) begin
         chk({req, " region"}, {30'd0, sel_region}, {30'd0, r});
         chk({req, " addr"}, {16'd0, sel_addr}, {16'd0, a[15:0]});
         if (r == 2'd1 || r == 2'd2) chk({req, " slot"}, {31'd0, sel_slot}, {31'd0, a[8]});
         if (rsp_valid) chk({req, " rdata"}, {16'd0, rsp_rdata}, {16'd0, e_rd});
         if (r == 2'd0 && wr && !sz[1]) model_write(a[15:0], d);
      end
      check_outputs(req);
   endtask

   function automatic logic [31:0] win_addr(logic [15:0] off);
      if (strap_ext) return {sw_hi, sw_lo, 8'h00, off};
      return {8'h00, sw_hi, sw_lo, off};
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = 7;
      void'($urandom(seed));
      foreach (m_win[i]) m_win[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state (R6 R7 R9)
      chk("R4 reset rsp", {31'd0, rsp_valid}, 32'd0);
      check_outputs("R6 R7 R9 reset");

      // identification (R5)
      access(win_addr(16'h0000), 1'b1, 1'b0, 2'd1, 16'h0, 2'b00, "R5 devid");
      access(win_addr(16'h0002), 1'b1, 1'b0, 2'd1, 16'h0, 2'b00, "R5 rev");
      access(win_addr(16'h0000), 1'b1, 1'b1, 2'd1, 16'hFFFF, 2'b00, "R5 devid write");
      access(win_addr(16'h0000), 1'b1, 1'b0, 2'd1, 16'h0, 2'b00, "R5 devid after write");
      access(win_addr(16'h0002), 1'b1, 1'b1, 2'd1, 16'h1234, 2'b00, "R5 rev write");
      access(win_addr(16'h0002), 1'b1, 1'b0, 2'd0, 16'h0, 2'b00, "R5 rev D8 read");
      // control all ones (R6), vector all ones (R7)
      access(win_addr(16'h0004), 1'b1, 1'b1, 2'd1, 16'hFFFF, 2'b00, "R6 ctl ones");
      access(win_addr(16'h0004), 1'b1, 1'b0, 2'd1, 16'h0, 2'b00, "R6 ctl read");
      access(win_addr(16'h0006), 1'b1, 1'b1, 2'd1, 16'hFFFF, 2'b00, "R7 vec ones");
      access(win_addr(16'h0006), 1'b1, 1'b0, 2'd1, 16'h0, 2'b00, "R7 vec read");
      // status (R8)
      access(win_addr(16'h0008), 1'b1, 1'b0, 2'd1, 16'h0, 2'b01, "R8 sts A");
      access(win_addr(16'h0008), 1'b1, 1'b0, 2'd1, 16'h0, 2'b10, "R8 sts B");
      access(win_addr(16'h0008), 1'b1, 1'b1, 2'd1, 16'hFFFF, 2'b11, "R8 sts write");
      // window words (R9)
      for (int i = 0; i < 6; i++)
         access(win_addr(16'h000A + 16'(2*i)), 1'b1, 1'b1, 2'd1, 16'h1111 * 16'(i+1), 2'b00, "R9 win write");
      for (int i = 0; i < 6; i++)
         access(win_addr(16'h000A + 16'(2*i)), 1'b1, 1'b0, 2'd1, 16'h0, 2'b00, "R9 win read");
      // wide register access (R10)
      access(win_addr(16'h0004), 1'b1, 1'b1, 2'd2, 16'h0000, 2'b00, "R10 D32 ctl write");
      access(win_addr(16'h000A), 1'b1, 1'b1, 2'd3, 16'h0000, 2'b00, "R10 rsv size write");
      access(win_addr(16'h0004), 1'b1, 1'b0, 2'd2, 16'h0, 2'b00, "R10 D32 read");
      access(win_addr(16'h0004), 1'b1, 1'b0, 2'd1, 16'h0, 2'b00, "R10 ctl kept");
      // empty register offsets and unmapped space (R11)
      access(win_addr(16'h0100), 1'b1, 1'b1, 2'd1, 16'hBEEF, 2'b00, "R11 empty reg write");
      access(win_addr(16'h0100), 1'b1, 1'b0, 2'd1, 16'h0, 2'b00, "R11 empty reg read");
      access(win_addr(16'h0804), 1'b1, 1'b1, 2'd2, 16'h0000, 2'b00, "R11 unmapped write");
      access(win_addr(16'hFFFE), 1'b1, 1'b0, 2'd2, 16'h0, 2'b00, "R11 unmapped read");
      // region boundaries (R3 R4)
      access(win_addr(16'h03FF), 1'b1, 1'b0, 2'd0, 16'h0, 2'b00, "R3 reg top");
      access(win_addr(16'h0400), 1'b1, 1'b0, 2'd2, 16'h0, 2'b00, "R3 cfg A");
      access(win_addr(16'h05FC), 1'b1, 1'b1, 2'd2, 16'h55, 2'b00, "R3 cfg B");
      access(win_addr(16'h0600), 1'b1, 1'b0, 2'd0, 16'h0, 2'b00, "R3 io A");
      access(win_addr(16'h07FF), 1'b1, 1'b1, 2'd1, 16'h0, 2'b00, "R4 io B");
      access(win_addr(16'h07FF) + 32'd1, 1'b1, 1'b0, 2'd1, 16'h0, 2'b00, "R3 first unmapped");
      // misses (R1 R12)
      access({sw_hi, sw_lo, 8'h01, 16'h0004}, 1'b1, 1'b0, 2'd1, 16'h0, 2'b00, "R1 mid byte miss");
      access({8'h00, sw_hi, sw_lo, 16'h0004}, 1'b1, 1'b1, 2'd1, 16'h0, 2'b00, "R1 std addr in ext");
      access(win_addr(16'h0004), 1'b0, 1'b1, 2'd1, 16'h0, 2'b00, "R12 space mismatch");
      // standard mode (R2 R12)
      strap_ext = 1'b0;
      access({8'hC3, sw_hi, sw_lo, 16'h0004}, 1'b0, 1'b0, 2'd1, 16'h0, 2'b00, "R2 upper ignored");
      access({8'h00, sw_hi, sw_lo, 16'h0500}, 1'b0, 1'b0, 2'd1, 16'h0, 2'b00, "R2 cfg B");
      access({8'h00, sw_hi, sw_lo ^ 4'h1, 16'h0004}, 1'b0, 1'b0, 2'd1, 16'h0, 2'b00, "R2 wrong sw");
      access({8'h00, sw_hi, sw_lo, 16'h0004}, 1'b1, 1'b0, 2'd1, 16'h0, 2'b00, "R12 ext in std");

      // constrained random mix
      for (int n = 0; n < 600; n++) begin
         logic [31:0] a;
         logic [15:0] off;
         logic ext;
         int kind;
         if (n % 150 == 0) begin
            strap_ext = $urandom_range(0, 1);
            sw_hi = 4'($urandom);
            sw_lo = 4'($urandom);
         end
         kind = $urandom_range(0, 9);
         case (kind)
            0:       off = 16'($urandom_range(16'h0800, 16'hFFFF));
            1, 2:    off = 16'($urandom_range(16'h0400, 16'h07FF));
            default: off = 16'($urandom_range(0, 16'h0017));
         endcase
         a = win_addr(off);
         if (kind == 3) a = $urandom;
         ext = ($urandom_range(0, 15) == 0) ? !strap_ext : strap_ext;
         access(a, ext, 1'($urandom), 2'($urandom_range(0, 4) == 0 ? 2 : $urandom_range(0, 1)),
                16'($urandom), 2'($urandom), "R3 R9 random");
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule